// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Re-arm

This block chooses, for each of two interrupt classes, the single most urgent request among up to 96 lines, organised as three banks of 32. The lines arrive already captured as pending bits, alongside a per-line mask bit, a per-line class-select bit that steers the line to the fast class instead of the normal class, and a per-line priority value. For each class the block latches the winning line number and raises that class's request output to the processor.

A class may fire only once per agreement. Each class holds an arm flag. When the class fires, the flag drops, and it stays down until software writes a re-arm bit for that class. Firing is considered only after a trigger. A trigger is either an evaluation pulse from the surrounding logic, sent when a new pending bit rises or the mask changes, or a re-arm of that class. A trigger sets a one-cycle search request, shown on the busy output. On the next edge, the latched line number and the request output update together.

Top module: `intc_arbiter`

## Requirements
- R1: After reset both request outputs are 0, both latched line numbers are 0, busy is 0 and both classes are armed.
- R2: A line competes in the normal class when pending=1, mask=0 and class-select=0. It competes in the fast class when pending=1, mask=0 and class-select=1.
- R3: Among the candidates of a class, the line with the smallest priority value wins. Value 0 is the most urgent.
- R4: When several candidates share the best priority value, the highest line index wins. The latched number is 32*bank + bit, which is the flat index into the 96-bit vectors.
- R5: A class fires only when it is armed, it has at least one candidate, and the global enable input is 1. Without a firing, the class stays armed and its output stays low.
- R6: Once a class has fired, its flag stays clear. Later triggers change neither its output nor its latched number until that class is re-armed.
- R7: Re-arm bit 0 is for the normal class and bit 1 is for the fast class. A re-arm drops that class's output on the next edge, arms it, and triggers a new search. The other class is unaffected.
- R8: A re-arm that finds no candidate leaves the output low and the class armed. A later evaluation pulse with a candidate present fires it.
- R9: A trigger sampled at edge k makes busy 1 for the cycle after edge k. The output and the latched number then change together at edge k+1, and busy returns to 0 if no new trigger arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pend_i | input | 96 | Captured pending bits, flat line index |
| mask_i | input | 96 | Mask bits, 1 blocks the line |
| fiq_sel_i | input | 96 | Class select, 1 steers the line to the fast class |
| prio_i | input | 576 | Priority of line i at bits [i*6 +: 6], 0 most urgent |
| glob_en_i | input | 1 | Global enable for firing |
| eval_i | input | 1 | Evaluation trigger for both classes |
| rearm_i | input | 2 | Re-arm: bit 0 normal class, bit 1 fast class |
| irq_o | output | 1 | Normal-class request |
| fiq_o | output | 1 | Fast-class request |
| irq_id_o | output | 7 | Latched normal-class winner |
| fiq_id_o | output | 7 | Latched fast-class winner |
| busy_o | output | 1 | A search is in flight |

## Verification
Three lines with distinct priorities, spread over all three banks, show whether selection follows the priority value or the index. Three lines with equal priority in different banks show the tie rule and the bank-to-number mapping. Moving one line into the fast class, and then masking another, shows that the two candidate sets are kept apart. Firing, then presenting a more urgent line without a re-arm, shows the agreement lock. Re-arming with the global enable off, and re-arming with nothing pending, show that the flag stays armed until a real candidate and an evaluation pulse arrive.

// File: rtl/intc_arb_pkg.sv
package intc_arb_pkg;
  localparam int unsigned NBANK  = 3;
  localparam int unsigned BANK_W = 32;
  localparam int unsigned PRIO_W = 6;
  localparam int unsigned NCLS   = 2;

  typedef enum logic {
    CLS_IRQ = 1'b0,
    CLS_FIQ = 1'b1
  } cls_e;
endpackage

// File: rtl/intc_cand.sv
module intc_cand #(
  parameter int unsigned N    = 96,
  parameter int unsigned NCLS = 2
) (
  input  logic [N-1:0]    pend_i,
  input  logic [N-1:0]    mask_i,
  input  logic [N-1:0]    fiq_sel_i,
  output logic [N-1:0]    cand_o [NCLS]
);
  logic [N-1:0] live;
  assign live = pend_i & ~mask_i;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    if (c == 0) begin : g_irq
      assign cand_o[c] = live & ~fiq_sel_i;
    end else begin : g_fiq
      assign cand_o[c] = live & fiq_sel_i;
    end
  end
endmodule

// File: rtl/intc_prio_tree.sv
module intc_prio_tree #(
  parameter int unsigned N  = 96,
  parameter int unsigned PW = 6,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned P  = 1 << IW
) (
  input  logic [N-1:0]    cand_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            win_v_o,
  output logic [IW-1:0]   win_id_o
);
  // Heap layout: node k combines 2k (lower index) and 2k+1 (higher index).
  logic          v  [1:2*P-1];
  logic [PW-1:0] p  [1:2*P-1];
  logic [IW-1:0] id [1:2*P-1];

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign v[P+i]  = cand_i[i];
      assign p[P+i]  = prio_i[i*PW +: PW];
      assign id[P+i] = IW'(i);
    end else begin : g_pad
      assign v[P+i]  = 1'b0;
      assign p[P+i]  = '1;
      assign id[P+i] = '0;
    end
  end

  for (genvar k = 1; k < P; k++) begin : g_node
    logic take_hi;
    // <= keeps the higher index on equal priority
    assign take_hi = v[2*k+1] && (!v[2*k] || (p[2*k+1] <= p[2*k]));
    assign v[k]  = v[2*k] | v[2*k+1];
    assign p[k]  = take_hi ? p[2*k+1]  : p[2*k];
    assign id[k] = take_hi ? id[2*k+1] : id[2*k];
  end

  assign win_v_o  = v[1];
  assign win_id_o = id[1];
endmodule

// File: rtl/intc_class_ctl.sv
module intc_class_ctl #(
  parameter int unsigned IW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic          rearm_i,
  input  logic          glob_en_i,
  input  logic          win_v_i,
  input  logic [IW-1:0] win_id_i,
  output logic          req_o,
  output logic          out_o,
  output logic [IW-1:0] id_o
);
  logic armed_q, req_q, out_q;
  logic [IW-1:0] id_q;
  logic fire;

  assign fire = req_q & armed_q & win_v_i & glob_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      req_q   <= 1'b0;
      out_q   <= 1'b0;
      id_q    <= '0;
    end else begin
      req_q <= trig_i | rearm_i;
      if (rearm_i) begin
        // re-arm beats a same-edge firing; search repeats next cycle
        out_q   <= 1'b0;
        armed_q <= 1'b1;
      end else if (fire) begin
        out_q   <= 1'b1;
        armed_q <= 1'b0;
        id_q    <= win_id_i;
      end
    end
  end

  assign req_o = req_q;
  assign out_o = out_q;
  assign id_o  = id_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_arb_pkg::*;
#(
  parameter int unsigned N_BANK = NBANK,
  parameter int unsigned B_W    = BANK_W,
  parameter int unsigned PW     = PRIO_W,
  localparam int unsigned N     = N_BANK * B_W,
  localparam int unsigned IW    = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    pend_i,
  input  logic [N-1:0]    mask_i,
  input  logic [N-1:0]    fiq_sel_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic            glob_en_i,
  input  logic            eval_i,
  input  logic [1:0]      rearm_i,
  output logic            irq_o,
  output logic            fiq_o,
  output logic [IW-1:0]   irq_id_o,
  output logic [IW-1:0]   fiq_id_o,
  output logic            busy_o
);
  logic [N-1:0]  cand [NCLS];
  logic          win_v  [NCLS];
  logic [IW-1:0] win_id [NCLS];
  logic          req [NCLS];
  logic          out [NCLS];
  logic [IW-1:0] id  [NCLS];

  intc_cand #(.N(N), .NCLS(NCLS)) u_cand (
    .pend_i    (pend_i),
    .mask_i    (mask_i),
    .fiq_sel_i (fiq_sel_i),
    .cand_o    (cand)
  );

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    intc_prio_tree #(.N(N), .PW(PW)) u_tree (
      .cand_i   (cand[c]),
      .prio_i   (prio_i),
      .win_v_o  (win_v[c]),
      .win_id_o (win_id[c])
    );

    intc_class_ctl #(.IW(IW)) u_ctl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .trig_i    (eval_i),
      .rearm_i   (rearm_i[c]),
      .glob_en_i (glob_en_i),
      .win_v_i   (win_v[c]),
      .win_id_i  (win_id[c]),
      .req_o     (req[c]),
      .out_o     (out[c]),
      .id_o      (id[c])
    );
  end

  assign irq_o    = out[CLS_IRQ];
  assign fiq_o    = out[CLS_FIQ];
  assign irq_id_o = id[CLS_IRQ];
  assign fiq_id_o = id[CLS_FIQ];
  assign busy_o   = req[CLS_IRQ] | req[CLS_FIQ];
endmodule

// File: rtl/intc_arbiter_chk.sv
module intc_arbiter_chk #(
  parameter int unsigned N  = 96,
  parameter int unsigned IW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  pend_i,
  input logic [N-1:0]  mask_i,
  input logic [N-1:0]  fiq_sel_i,
  input logic          glob_en_i,
  input logic [1:0]    rearm_i,
  input logic          irq_o,
  input logic          fiq_o,
  input logic [IW-1:0] irq_id_o,
  input logic [IW-1:0] fiq_id_o,
  input logic          busy_o
);
  localparam logic [N-1:0] ONE = N'(1);
  logic [N-1:0] irq_c, fiq_c;
  assign irq_c = pend_i & ~mask_i & ~fiq_sel_i;
  assign fiq_c = pend_i & ~mask_i & fiq_sel_i;

  a_r2_irq_cand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((($past(irq_c)) >> irq_id_o) & ONE) != '0);
  a_r2_fiq_cand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fiq_o) |-> ((($past(fiq_c)) >> fiq_id_o) & ONE) != '0);
  a_r4_id_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(irq_id_o) < N) && (32'(fiq_id_o) < N));
  a_r5_glob_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) || $rose(fiq_o)) |-> $past(glob_en_i));
  a_r6_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(irq_o)) |-> $stable(irq_id_o));
  a_r6_fiq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_o && $past(fiq_o)) |-> $stable(fiq_id_o));
  a_r7_irq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i[0] |=> !irq_o);
  a_r7_fiq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i[1] |=> !fiq_o);
  a_r9_rise_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) || $rose(fiq_o)) |-> $past(busy_o));
  a_r9_id_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(irq_id_o) || !$stable(fiq_id_o)) |-> $past(busy_o));
endmodule

bind intc_arbiter intc_arbiter_chk #(.N(N), .IW(IW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pend_i    (pend_i),
  .mask_i    (mask_i),
  .fiq_sel_i (fiq_sel_i),
  .glob_en_i (glob_en_i),
  .rearm_i   (rearm_i),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .irq_id_o  (irq_id_o),
  .fiq_id_o  (fiq_id_o),
  .busy_o    (busy_o)
);

// File: tb/tb_intc_arbiter.sv
`timescale 1ns/1ps
module tb_intc_arbiter;
  localparam int N  = 96;
  localparam int PW = 6;
  localparam int IW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    pend = '0, mask = '1, fsel = '0;
  logic [N*PW-1:0] prio = '0;
  logic glob_en = 1'b1, eval = 1'b0;
  logic [1:0] rearm = 2'b00;
  logic irq, fiq, busy;
  logic [IW-1:0] irq_id, fiq_id;

  int vecs = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  intc_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .mask_i(mask),
    .fiq_sel_i(fsel), .prio_i(prio), .glob_en_i(glob_en), .eval_i(eval),
    .rearm_i(rearm), .irq_o(irq), .fiq_o(fiq), .irq_id_o(irq_id),
    .fiq_id_o(fiq_id), .busy_o(busy)
  );

  // behavioural reference
  bit m_arm[2], m_req[2], m_out[2];
  int m_id[2];

  function automatic int pick(input bit cls);
    int best = -1;
    int bp = 0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && !mask[i] && (fsel[i] == cls)) begin
        if (best < 0 || int'(prio[i*PW +: PW]) <= bp) begin
          best = i;
          bp = int'(prio[i*PW +: PW]);
        end
      end
    end
    return best;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_arm[c] = 1; m_req[c] = 0; m_out[c] = 0; m_id[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int w;
        bit oreq;
        w = pick(c[0]);
        oreq = m_req[c];
        m_req[c] = eval | rearm[c];
        if (rearm[c]) begin
          m_out[c] = 0; m_arm[c] = 1;
        end else if (oreq && m_arm[c] && w >= 0 && glob_en) begin
          m_out[c] = 1; m_arm[c] = 0; m_id[c] = w;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " irq_o"}, int'(irq), int'(m_out[0]));
      chk({cur_req, " fiq_o"}, int'(fiq), int'(m_out[1]));
      chk({cur_req, " irq_id"}, int'(irq_id), m_id[0]);
      chk({cur_req, " fiq_id"}, int'(fiq_id), m_id[1]);
      chk({cur_req, " busy"}, int'(busy), int'(m_req[0] | m_req[1]));
    end
  end

  task automatic trigger(input bit ev, input logic [1:0] ra);
    @(posedge clk); #1;
    eval = ev; rearm = ra;
    @(posedge clk); #1;
    eval = 0; rearm = 2'b00;
    chk("R9 busy after trigger", int'(busy), 1);
    if (ra[0]) chk("R7 irq dropped", int'(irq), 0);
    if (ra[1]) chk("R7 fiq dropped", int'(fiq), 0);
    @(posedge clk); #1;
    chk("R9 busy clears", int'(busy), 0);
  endtask

  task automatic set_line(input int ln, input int pv);
    pend[ln] = 1'b1;
    prio[ln*PW +: PW] = PW'(pv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R1 irq reset", int'(irq), 0);
    chk("R1 fiq reset", int'(fiq), 0);
    chk("R1 irq_id reset", int'(irq_id), 0);
    chk("R1 fiq_id reset", int'(fiq_id), 0);
    chk("R1 busy reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    cur_req = "R3";
    mask = '0;
    set_line(5, 10); set_line(40, 3); set_line(70, 7);
    trigger(1, 2'b00);
    chk("R3 irq fired", int'(irq), 1);
    chk("R3 lowest value wins", int'(irq_id), 40);
    chk("R2 no fast candidate", int'(fiq), 0);

    cur_req = "R6";
    set_line(2, 0);
    trigger(1, 2'b00);
    chk("R6 id locked", int'(irq_id), 40);
    chk("R6 output held", int'(irq), 1);

    cur_req = "R7";
    trigger(0, 2'b01);
    chk("R7 refired id", int'(irq_id), 2);
    chk("R7 fast class untouched", int'(fiq), 0);

    cur_req = "R4";
    pend = '0; prio = '0;
    set_line(10, 4); set_line(33, 4); set_line(90, 4);
    trigger(0, 2'b01);
    chk("R4 tie highest index 32*2+26", int'(irq_id), 90);

    cur_req = "R2";
    fsel[90] = 1'b1;
    trigger(0, 2'b11);
    chk("R2 normal winner", int'(irq_id), 33);
    chk("R2 fast winner", int'(fiq_id), 90);
    chk("R2 fast fired", int'(fiq), 1);
    mask[33] = 1'b1;
    trigger(0, 2'b01);
    chk("R2 masked line skipped", int'(irq_id), 10);

    cur_req = "R5";
    glob_en = 1'b0;
    trigger(0, 2'b11);
    chk("R5 no fire when disabled irq", int'(irq), 0);
    chk("R5 no fire when disabled fiq", int'(fiq), 0);
    @(posedge clk); #1; glob_en = 1'b1;
    repeat (2) @(posedge clk); #1;
    chk("R5 no fire without trigger", int'(irq), 0);
    trigger(1, 2'b00);
    chk("R5 fires once enabled irq", int'(irq), 1);
    chk("R5 fires once enabled fiq", int'(fiq), 1);

    cur_req = "R8";
    pend = '0;
    trigger(0, 2'b11);
    repeat (2) @(posedge clk); #1;
    chk("R8 stays low irq", int'(irq), 0);
    chk("R8 stays low fiq", int'(fiq), 0);
    set_line(50, 1);
    trigger(1, 2'b00);
    chk("R8 later fire irq", int'(irq), 1);
    chk("R8 later id", int'(irq_id), 50);
    chk("R8 fast still waiting", int'(fiq), 0);
    fsel[60] = 1'b1; set_line(60, 2);
    trigger(1, 2'b00);
    chk("R8 fast fires", int'(fiq), 1);
    chk("R8 fast id", int'(fiq_id), 60);
    chk("R6 normal still locked", int'(irq_id), 50);

    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule